// File: doc/BRIEF.md
# Filtered Event Counter Bank

This block counts hardware events for performance monitoring. It holds eight 64-bit counters behind a memory-mapped register port. Each counter chooses one strobe from a 256-wide event vector by its own 8-bit event code. A counter counts only when three conditions hold together: the bank is started, its own enable bit is set, and the transaction qualifiers pass. The qualifiers are a target-ID match, a source-ID match and an optional trace-tag requirement. All three qualifiers apply to every counter in the same cycle.

When a counter wraps from all ones to zero, it sets a sticky status bit. The status bits, after a per-counter mask, drive a single interrupt line. Software sets up the codes, filters and enables through the register port, then reads the counters back as 64-bit values. Status bits are acknowledged by writing ones to a clear register.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset, all counters read zero. The start bit, the enable bitmap, the event codes, the filters, the trace qualifier and the status bits also read zero. The interrupt mask at 0x1c70 reads 0xFF, and irq_o is low.
- R2: Counter i increments by exactly one in each cycle where all of these hold: bit 0 of 0x1c00 is 1, bit i of 0x1c04 is 1, every qualifier passes, and the strobe chosen by its code is high. In any other cycle the counter holds its value.
- R3: The event code of counter i sits in the select register at 0x1c80 + 4*(i/4), in bits [8*(i%4)+7 : 8*(i%4)]. The code is the index of the evt_i bit that the counter watches. Select registers read back their codes.
- R4: Counter i is read and written as one 64-bit word at 0x1d00 + 8*i. A write replaces the value, and it wins over an increment in the same cycle.
- R5: The target filter is at 0x1c14 and the source filter is at 0x1c18. Each has the command in bits [10:0], the enable in bit 11 and the mask in bits [22:12]. A filter passes when its enable is 0, or when (id AND mask) equals (command AND mask). Writing zero disables the filter.
- R6: When bit 4 of 0x1c08 is 1, only cycles with trace_tag_i high count. When the bit is 0, the tag is ignored.
- R7: A wrap from all ones to zero sets status bit i, which reads at 0x1c78.
- R8: Writing a 1 to bit i of 0x1c7c clears status bit i. Writing 0 bits has no effect. An overflow in the same cycle as the clear wins, so the bit stays set.
- R9: irq_o is high exactly when some status bit is set and its mask bit at 0x1c70 is 0.
- R10: The register at 0x1cf0 reads the VERSION parameter and ignores writes.
- R11: A read returns its data on rdata_o one clock after the request. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 64 | Write data (32-bit registers use bits [31:0]) |
| rdata_o | output | 64 | Read data, registered |
| evt_i | input | 256 | Event strobes, one per event code |
| src_id_i | input | 11 | Source ID of the current transaction |
| tgt_id_i | input | 11 | Target ID of the current transaction |
| trace_tag_i | input | 1 | Trace tag of the current transaction |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Timing of each result:

- A register write and an event strobe both take effect at the rising edge that samples them, so counters, status and irq_o change after that one edge.
- Read data passes through a single output register, so it is due one edge after the read request.

How the bench keeps to this timing:

- It drives every input on the falling edge.
- It samples outputs on the next falling edge, which is half a period after the edge that updated them.
- Counter values are always read through the port, so each counter result is checked two edges after its strobe.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned ID_W   = 11;

  localparam logic [ADDR_W-1:0] OFS_GLB  = 16'h1c00;
  localparam logic [ADDR_W-1:0] OFS_ENA  = 16'h1c04;
  localparam logic [ADDR_W-1:0] OFS_TT   = 16'h1c08;
  localparam logic [ADDR_W-1:0] OFS_TGT  = 16'h1c14;
  localparam logic [ADDR_W-1:0] OFS_SRC  = 16'h1c18;
  localparam logic [ADDR_W-1:0] OFS_MASK = 16'h1c70;
  localparam logic [ADDR_W-1:0] OFS_STAT = 16'h1c78;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 16'h1c7c;
  localparam logic [ADDR_W-1:0] OFS_SEL  = 16'h1c80;
  localparam logic [ADDR_W-1:0] OFS_VER  = 16'h1cf0;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 16'h1d00;

  localparam int unsigned TT_BIT = 4;

  typedef struct packed {
    logic [ID_W-1:0] msk;
    logic            en;
    logic [ID_W-1:0] cmd;
  } filt_t;

  localparam int unsigned FILT_W = $bits(filt_t);
endpackage

// File: rtl/id_filter.sv
module id_filter
  import evt_ctr_pkg::*;
(
  input  filt_t           cfg_i,
  input  logic [ID_W-1:0] id_i,
  output logic            pass_o
);
  assign pass_o = ~cfg_i.en | ((id_i & cfg_i.msk) == (cfg_i.cmd & cfg_i.msk));
endmodule

// File: rtl/evt_pick.sv
module evt_pick #(
  parameter int unsigned CODE_W = 8,
  localparam int unsigned NUM_EVT = 1 << CODE_W
) (
  input  logic [CODE_W-1:0]  code_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  assign hit_o = evt_i[code_i];
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice #(
  parameter int unsigned CTR_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [CTR_W-1:0] wdata_i,
  output logic [CTR_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CTR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  // software write overrides the step, so no wrap then
  assign wrap_o = inc_i & ~wr_i & (&cnt_q);
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_ctr_pkg::*;
#(
  parameter int unsigned NUM_CTR = 8,
  parameter int unsigned CTR_W   = 64,
  parameter int unsigned CODE_W  = 8,
  parameter logic [31:0] VERSION = 32'h0000_0030,
  localparam int unsigned NUM_EVT = 1 << CODE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CTR_W-1:0]   wdata_i,
  output logic [CTR_W-1:0]   rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ID_W-1:0]    src_id_i,
  input  logic [ID_W-1:0]    tgt_id_i,
  input  logic               trace_tag_i,
  output logic               irq_o
);
  localparam int unsigned CPR     = 32 / CODE_W;
  localparam int unsigned NUM_SEL = (NUM_CTR + CPR - 1) / CPR;

  function automatic logic [ADDR_W-1:0] cnt_addr(int unsigned i);
    return ADDR_W'(32'(OFS_CNT) + 8 * i);
  endfunction

  function automatic logic [ADDR_W-1:0] sel_addr(int unsigned j);
    return ADDR_W'(32'(OFS_SEL) + 4 * j);
  endfunction

  logic wr_en, rd_en;
  assign wr_en = req_i & we_i;
  assign rd_en = req_i & ~we_i;

  logic                   glb_en;
  logic [NUM_CTR-1:0]     ena_q, mask_q, status_q;
  logic                   tt_q;
  filt_t                  tgt_q, src_q;
  logic [CODE_W-1:0]      code_q [NUM_CTR];
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt;
  logic [NUM_CTR-1:0]     ctr_wr, inc, wrap, hit;
  logic [NUM_SEL-1:0]     sel_wr;
  logic                   clr_stb;
  logic [NUM_CTR-1:0]     clr_bits;
  logic                   tgt_pass, src_pass, tt_pass, qual;

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en <= 1'b0;
      ena_q  <= '0;
      mask_q <= '1;
      tt_q   <= 1'b0;
      tgt_q  <= '0;
      src_q  <= '0;
    end else if (wr_en) begin
      if (addr_i == OFS_GLB)  glb_en <= wdata_i[0];
      if (addr_i == OFS_ENA)  ena_q  <= wdata_i[NUM_CTR-1:0];
      if (addr_i == OFS_MASK) mask_q <= wdata_i[NUM_CTR-1:0];
      if (addr_i == OFS_TT)   tt_q   <= wdata_i[TT_BIT];
      if (addr_i == OFS_TGT)  tgt_q  <= filt_t'(wdata_i[FILT_W-1:0]);
      if (addr_i == OFS_SRC)  src_q  <= filt_t'(wdata_i[FILT_W-1:0]);
    end
  end

  // transaction qualifiers, shared by every counter
  id_filter u_tgt_filt (.cfg_i(tgt_q), .id_i(tgt_id_i), .pass_o(tgt_pass));
  id_filter u_src_filt (.cfg_i(src_q), .id_i(src_id_i), .pass_o(src_pass));
  assign tt_pass = ~tt_q | trace_tag_i;
  assign qual    = glb_en & tgt_pass & src_pass & tt_pass;

  for (genvar j = 0; j < NUM_SEL; j++) begin : g_sel
    assign sel_wr[j] = wr_en & (addr_i == sel_addr(j));
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              code_q[i] <= '0;
      else if (sel_wr[i / CPR]) code_q[i] <= wdata_i[(i % CPR) * CODE_W +: CODE_W];
    end

    evt_pick #(.CODE_W(CODE_W)) u_pick (
      .code_i(code_q[i]), .evt_i(evt_i), .hit_o(hit[i])
    );

    assign ctr_wr[i] = wr_en & (addr_i == cnt_addr(i));
    assign inc[i]    = qual & ena_q[i] & hit[i];

    ctr_slice #(.CTR_W(CTR_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[i]),
      .wr_i   (ctr_wr[i]),
      .wdata_i(wdata_i),
      .cnt_o  (cnt[i]),
      .wrap_o (wrap[i])
    );
  end

  // overflow status: set wins over a clear in the same cycle
  assign clr_stb  = wr_en & (addr_i == OFS_CLR);
  assign clr_bits = clr_stb ? wdata_i[NUM_CTR-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_bits) | wrap;
  end

  assign irq_o = |(status_q & ~mask_q);

  // read path
  logic [CTR_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (addr_i == OFS_GLB)  rd_val = CTR_W'(glb_en);
    if (addr_i == OFS_ENA)  rd_val = CTR_W'(ena_q);
    if (addr_i == OFS_MASK) rd_val = CTR_W'(mask_q);
    if (addr_i == OFS_STAT) rd_val = CTR_W'(status_q);
    if (addr_i == OFS_TT)   rd_val = CTR_W'({tt_q, {TT_BIT{1'b0}}});
    if (addr_i == OFS_TGT)  rd_val = CTR_W'(tgt_q);
    if (addr_i == OFS_SRC)  rd_val = CTR_W'(src_q);
    if (addr_i == OFS_VER)  rd_val = CTR_W'(VERSION);
    for (int unsigned j = 0; j < NUM_SEL; j++) begin
      if (addr_i == sel_addr(j)) begin
        for (int unsigned k = 0; k < CPR; k++) begin
          if (j * CPR + k < NUM_CTR) rd_val[k * CODE_W +: CODE_W] = code_q[j * CPR + k];
        end
      end
    end
    for (int unsigned i = 0; i < NUM_CTR; i++) begin
      if (addr_i == cnt_addr(i)) rd_val = cnt[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_val;
  end
endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk
  import evt_ctr_pkg::*;
#(
  parameter int unsigned NUM_CTR = 8,
  parameter int unsigned CTR_W   = 64,
  parameter logic [31:0] VERSION = 32'h0
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_i,
  input logic                          we_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [CTR_W-1:0]              rdata_o,
  input logic                          glb_en,
  input logic [NUM_CTR-1:0]            inc,
  input logic [NUM_CTR-1:0]            ctr_wr,
  input logic [NUM_CTR-1:0][CTR_W-1:0] cnt,
  input logic [NUM_CTR-1:0]            status_q,
  input logic [NUM_CTR-1:0]            wrap,
  input logic                          clr_stb,
  input logic [NUM_CTR-1:0]            clr_bits,
  input logic                          irq_o
);
  assert_hold_when_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en && ctr_wr == '0) |=> $stable(cnt));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    assert_step_by_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc[i] && !ctr_wr[i]) |=> cnt[i] == $past(cnt[i]) + 1'b1);

    assert_wrap_sets_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc[i] && !ctr_wr[i] && (&cnt[i])) |=> (status_q[i] && cnt[i] == '0));
  end

  assert_clear_takes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_stb |=> (status_q & $past(clr_bits) & ~$past(wrap)) == '0);

  assert_no_irq_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q == '0) |-> !irq_o);

  assert_version_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_VER) |=> rdata_o == CTR_W'(VERSION));
endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .VERSION(VERSION)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .glb_en  (glb_en),
  .inc     (inc),
  .ctr_wr  (ctr_wr),
  .cnt     (cnt),
  .status_q(status_q),
  .wrap    (wrap),
  .clr_stb (clr_stb),
  .clr_bits(clr_bits),
  .irq_o   (irq_o)
);

// File: tb/evt_ctr_bank_tb_top.sv
`timescale 1ns/1ps
module evt_ctr_bank_tb_top;
  localparam logic [31:0] VER = 32'h0000_0030;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [255:0] evt = '0;
  logic [10:0] sid = '0, tid = '0;
  logic        tag = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_ctr_bank #(.VERSION(VER)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .src_id_i(sid),
    .tgt_id_i(tid), .trace_tag_i(tag), .irq_o(irq)
  );

  task automatic check(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [63:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [63:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic pulse(int code, int cycles);
    @(negedge clk); evt[code] = 1'b1;
    repeat (cycles) @(negedge clk);
    evt = '0;
  endtask

  typedef struct packed {
    logic [22:0] tgt;
    logic [22:0] src;
    logic        tt;
    logic [10:0] tid;
    logic [10:0] sid;
    logic        tag;
    logic        exp;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{23'h0,      23'h0,      1'b0, 11'h5a5, 11'h0a0, 1'b0, 1'b1},
    '{23'h7FF923, 23'h0,      1'b0, 11'h123, 11'h000, 1'b0, 1'b1},
    '{23'h7FF923, 23'h0,      1'b0, 11'h124, 11'h000, 1'b0, 1'b0},
    '{23'h7F0920, 23'h0,      1'b0, 11'h12F, 11'h000, 1'b0, 1'b1},
    '{23'h0,      23'h0FF855, 1'b0, 11'h000, 11'h355, 1'b0, 1'b1},
    '{23'h0,      23'h0FF855, 1'b0, 11'h000, 11'h356, 1'b0, 1'b0},
    '{23'h0,      23'h0,      1'b1, 11'h000, 11'h000, 1'b0, 1'b0},
    '{23'h0,      23'h0,      1'b1, 11'h000, 11'h000, 1'b1, 1'b1},
    '{23'h7FF923, 23'h0FF855, 1'b0, 11'h123, 11'h356, 1'b0, 1'b0},
    '{23'h000FFF, 23'h0,      1'b0, 11'h001, 11'h000, 1'b0, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(16'h1c70, d); check("R1 mask", d, 64'hFF);
    rd(16'h1c78, d); check("R1 status", d, 64'h0);
    rd(16'h1c04, d); check("R1 enable", d, 64'h0);
    rd(16'h1d18, d); check("R1 counter3", d, 64'h0);
    check("R1 irq", 64'(irq), 64'h0);
    // R10 / R11
    rd(16'h1cf0, d); check("R10 version", d, 64'(VER));
    wr(16'h1cf0, 64'hDEAD);
    rd(16'h1cf0, d); check("R10 write ignored", d, 64'(VER));
    rd(16'h1c0c, d); check("R11 unmapped", d, 64'h0);

    // R5 R6 table: counter 0 watches code 0x40
    wr(16'h1c80, 64'h40);
    wr(16'h1c04, 64'h01);
    wr(16'h1c00, 64'h1);
    for (int n = 0; n < 10; n++) begin
      wr(16'h1c14, 64'(VEC[n].tgt));
      wr(16'h1c18, 64'(VEC[n].src));
      wr(16'h1c08, VEC[n].tt ? 64'h10 : 64'h0);
      wr(16'h1d00, 64'h0);
      @(negedge clk); tid = VEC[n].tid; sid = VEC[n].sid; tag = VEC[n].tag;
      pulse(8'h40, 1);
      tid = '0; sid = '0; tag = 0;
      rd(16'h1d00, d);
      check($sformatf("R5 R6 vector %0d", n), d, 64'(VEC[n].exp));
    end
    wr(16'h1c14, 64'h0);
    wr(16'h1c18, 64'h0);
    wr(16'h1c08, 64'h0);

    // R3 code packing: counter 5 code 0x77 in bits [15:8] of 0x1c84
    wr(16'h1c84, 64'h7700);
    rd(16'h1c84, d); check("R3 select readback", d, 64'h7700);
    wr(16'h1c04, 64'h30);
    pulse(8'h77, 1);
    rd(16'h1d28, d); check("R3 counter5 hit", d, 64'h1);
    rd(16'h1d20, d); check("R3 counter4 not hit", d, 64'h0);

    // R2 gating and multi-cycle count
    wr(16'h1c00, 64'h0);
    pulse(8'h77, 1);
    rd(16'h1d28, d); check("R2 global off", d, 64'h1);
    wr(16'h1c00, 64'h1);
    wr(16'h1c04, 64'h10);
    pulse(8'h77, 1);
    rd(16'h1d28, d); check("R2 counter enable off", d, 64'h1);
    wr(16'h1c04, 64'h20);
    pulse(8'h77, 3);
    rd(16'h1d28, d); check("R2 three cycles", d, 64'h4);

    // R4 write, and write beats increment
    wr(16'h1d28, 64'h1234_5678_9abc_def0);
    rd(16'h1d28, d); check("R4 readback", d, 64'h1234_5678_9abc_def0);
    @(negedge clk); req = 1; we = 1; addr = 16'h1d28; wdata = 64'h55; evt[8'h77] = 1;
    @(negedge clk); req = 0; we = 0; evt = '0;
    rd(16'h1d28, d); check("R4 write wins", d, 64'h55);

    // R7 R9 R8 overflow path
    wr(16'h1d28, '1);
    pulse(8'h77, 1);
    rd(16'h1d28, d); check("R7 wrapped", d, 64'h0);
    rd(16'h1c78, d); check("R7 status", d, 64'h20);
    check("R9 masked", 64'(irq), 64'h0);
    wr(16'h1c70, 64'hDF);
    check("R9 unmasked", 64'(irq), 64'h1);
    wr(16'h1c7c, 64'h10);
    rd(16'h1c78, d); check("R8 other bit no effect", d, 64'h20);
    wr(16'h1c7c, 64'h20);
    rd(16'h1c78, d); check("R8 cleared", d, 64'h0);
    check("R9 irq dropped", 64'(irq), 64'h0);
    wr(16'h1d28, '1);
    @(negedge clk); req = 1; we = 1; addr = 16'h1c7c; wdata = 64'h20; evt[8'h77] = 1;
    @(negedge clk); req = 0; we = 0; evt = '0;
    rd(16'h1c78, d); check("R8 set wins over clear", d, 64'h20);
    check("R9 irq after race", 64'(irq), 64'h1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule